// File: doc/BRIEF.md
# Configurable AND-OR Logic Array

This block is a two-level sum-of-products fabric. Each primary input is offered to an AND plane both as itself and as its inverse. Each of the product-term gates in that plane keeps only the literals whose connection bit is set. An OR plane then forms every output from the product terms whose connection bit is set in that output's row. The connection bits stand in for fuses: a 1 is an intact link and a 0 is a broken one.

Two elaboration parameters choose, for each plane, whether it is fixed or loadable. This gives one fabric with three personalities:

- **Decoder-fed memory style:** a fixed AND plane that decodes every input combination, feeding a loadable OR plane.
- **Fully loadable array:** both planes loadable.
- **Grouped-term style:** a loadable AND plane feeding a fixed OR plane, in which every output owns a private group of terms.

The fuse map is loaded one row per clock through a word-wide port while a load-enable input is held. An erase command returns every loadable link to the intact state. The evaluation path from inputs to outputs is purely combinational.

Top module: `cfg_logic_array`

## Requirements
- R1: Product term k is the AND of the literals connected in AND row k. Row bit 2i connects input i uncomplemented, and row bit 2i+1 connects input i complemented.
- R2: Output j is the OR of every product term k whose bit k is 1 in OR row j.
- R3: A product term with no connected literal evaluates to 1. A term that connects both forms of any one input evaluates to 0, so a term with every link intact is 0.
- R4: An output whose OR row has no connected term is 0.
- R5: Reset, and a cycle with cfg_erase high while load_en is high, set every bit of the loadable planes to 1. In the fully loadable array every output is then 0 for every input value.
- R6: While load_en is high, a clock edge with cfg_we high and cfg_erase low writes cfg_data into row cfg_addr of the plane named by cfg_plane (0 = AND, 1 = OR). A write made while load_en is low, or one naming an OR row at or above the output count, changes nothing.
- R7: While load_en is high, every output is 0.
- R8: With the AND plane fixed, the number of product terms equals 2 to the power of the input count. Term k is 1 exactly when the input word equals k. Writes to the AND plane are ignored.
- R9: With the OR plane fixed, output j is the OR of terms j*G through j*G+G-1, where G is the term count divided by the output count. Writes to the OR plane are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset to the erased map |
| load_en | input | 1 | Configuration window; forces outputs to 0 |
| cfg_we | input | 1 | Row write strobe |
| cfg_erase | input | 1 | Erase all loadable links |
| cfg_plane | input | 1 | Target plane: 0 = AND, 1 = OR |
| cfg_addr | input | AW (4) | Row index within the target plane |
| cfg_data | input | CW (16) | Row contents; the AND plane uses the low 2*NIN bits |
| x | input | NIN (4) | Logic inputs |
| y | output | NOUT (4) | Sum-of-products outputs |

## Verification
The bench runs the three personalities side by side on a shared configuration bus, so each write also reaches the planes that must ignore it. A decoder-style instance that took AND writes would stop following input equality.

Blank terms and self-contradicting terms are checked directly. A fabric that treated an empty term as 0, or that dropped complement literals, would give wrong outputs in the input sweep.

Erase is checked directly. An erase that missed some rows would leave an output high.

Writes made outside the load window, writes to an OR row out of range, and evaluation during loading are all exercised. Any leak would show up as changed outputs, or as nonzero outputs while loading.

// File: rtl/cfg_logic_array.sv
module cfg_logic_array #(
  parameter int NIN = 4,
  parameter int NTERM = 16,
  parameter int NOUT = 4,
  parameter bit AND_FIXED = 1'b0,
  parameter bit OR_FIXED = 1'b0,
  localparam int LW = 2 * NIN,
  localparam int CW = (LW > NTERM) ? LW : NTERM,
  localparam int TAW = (NTERM > 1) ? $clog2(NTERM) : 1,
  localparam int OAW = (NOUT > 1) ? $clog2(NOUT) : 1,
  localparam int AW = (TAW > OAW) ? TAW : OAW,
  localparam int G = NTERM / NOUT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic            cfg_we,
  input  logic            cfg_erase,
  input  logic            cfg_plane,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [CW-1:0]   cfg_data,
  input  logic [NIN-1:0]  x,
  output logic [NOUT-1:0] y
);

  localparam logic [AW:0] NT_LIM = (AW+1)'(NTERM);
  localparam logic [AW:0] NO_LIM = (AW+1)'(NOUT);

  logic [LW-1:0]    and_map [NTERM];
  logic [NTERM-1:0] or_map  [NOUT];
  logic [LW-1:0]    lits;
  logic [NTERM-1:0] term;
  logic [NOUT-1:0]  raw;

  wire and_wr = load_en && cfg_we && !cfg_erase && !cfg_plane && ({1'b0, cfg_addr} < NT_LIM);
  wire or_wr  = load_en && cfg_we && !cfg_erase &&  cfg_plane && ({1'b0, cfg_addr} < NO_LIM);
  wire wipe   = load_en && cfg_erase;

  function automatic logic [LW-1:0] minterm_row(int k);
    logic [LW-1:0] r;
    for (int i = 0; i < NIN; i++) begin
      r[2*i]   = ((k >> i) & 1) == 1;
      r[2*i+1] = ((k >> i) & 1) == 0;
    end
    return r;
  endfunction

  function automatic logic [NTERM-1:0] group_row(int j);
    logic [NTERM-1:0] r;
    for (int k = 0; k < NTERM; k++) r[k] = (k / G) == j;
    return r;
  endfunction

  generate
    if (AND_FIXED) begin : g_and_fixed
      for (genvar k = 0; k < NTERM; k++) begin : g_row
        assign and_map[k] = minterm_row(k);
      end
      assert_single_minterm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(term) == 1);
    end else begin : g_and_prog
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < NTERM; k++) and_map[k] <= '1;
        end else if (wipe) begin
          for (int k = 0; k < NTERM; k++) and_map[k] <= '1;
        end else if (and_wr) begin
          and_map[cfg_addr[TAW-1:0]] <= cfg_data[LW-1:0];
        end
      end
      assert_and_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        and_wr |=> and_map[$past(cfg_addr[TAW-1:0])] == $past(cfg_data[LW-1:0]));
      for (genvar k = 0; k < NTERM; k++) begin : g_wipe_chk
        assert_and_erased_R5: assert property (@(posedge clk) disable iff (!rst_n)
          wipe |=> and_map[k] == '1);
      end
    end

    if (OR_FIXED) begin : g_or_fixed
      for (genvar j = 0; j < NOUT; j++) begin : g_row
        assign or_map[j] = group_row(j);
        assert_group_R9: assert property (@(posedge clk) disable iff (!rst_n)
          (!load_en && |term[j*G +: G]) |-> y[j]);
      end
    end else begin : g_or_prog
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int j = 0; j < NOUT; j++) or_map[j] <= '1;
        end else if (wipe) begin
          for (int j = 0; j < NOUT; j++) or_map[j] <= '1;
        end else if (or_wr) begin
          or_map[cfg_addr[OAW-1:0]] <= cfg_data[NTERM-1:0];
        end
      end
      for (genvar j = 0; j < NOUT; j++) begin : g_empty_chk
        assert_empty_or_R4: assert property (@(posedge clk) disable iff (!rst_n)
          (!load_en && or_map[j] == '0) |-> !y[j]);
      end
    end
  endgenerate

  always_comb begin
    for (int i = 0; i < NIN; i++) begin
      lits[2*i]   = x[i];
      lits[2*i+1] = ~x[i];
    end
  end

  generate
    for (genvar k = 0; k < NTERM; k++) begin : g_term
      assign term[k] = &(~and_map[k] | lits);
      assert_blank_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (and_map[k] == '0) |-> term[k]);
      assert_clash_term_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (&and_map[k][1:0]) |-> !term[k]);
    end
    for (genvar j = 0; j < NOUT; j++) begin : g_sum
      assign raw[j] = |(or_map[j] & term);
    end
  endgenerate

  assign y = load_en ? '0 : raw;

endmodule

// File: tb/cfg_logic_array_tb.sv
`timescale 1ns/1ps
module cfg_logic_array_tb;
  localparam int NI = 4, NT = 16, NO = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load_en = 1'b0, cfg_we = 1'b0, cfg_erase = 1'b0, cfg_plane = 1'b0;
  logic [3:0] cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic [NI-1:0] x = '0;
  logic [NO-1:0] y_pla, y_rom, y_pal;

  always #4 clk = ~clk;

  cfg_logic_array #(.NIN(NI), .NTERM(NT), .NOUT(NO), .AND_FIXED(1'b0), .OR_FIXED(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .cfg_we(cfg_we), .cfg_erase(cfg_erase),
    .cfg_plane(cfg_plane), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .x(x), .y(y_pla));
  cfg_logic_array #(.NIN(NI), .NTERM(NT), .NOUT(NO), .AND_FIXED(1'b1), .OR_FIXED(1'b0)) u_dut_rom (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .cfg_we(cfg_we), .cfg_erase(cfg_erase),
    .cfg_plane(cfg_plane), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .x(x), .y(y_rom));
  cfg_logic_array #(.NIN(NI), .NTERM(NT), .NOUT(NO), .AND_FIXED(1'b0), .OR_FIXED(1'b1)) u_dut_pal (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .cfg_we(cfg_we), .cfg_erase(cfg_erase),
    .cfg_plane(cfg_plane), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .x(x), .y(y_pal));

  logic [7:0] am [NT];
  logic [15:0] om [NO];

  typedef struct {
    logic [NO-1:0] pla;
    logic [NO-1:0] rom;
    logic [NO-1:0] pal;
    string tag;
  } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  function automatic logic lit_term(logic [7:0] row, logic [3:0] v);
    logic t = 1'b1;
    for (int i = 0; i < NI; i++) begin
      if (row[2*i] && !v[i]) t = 1'b0;
      if (row[2*i+1] && v[i]) t = 1'b0;
    end
    return t;
  endfunction

  function automatic logic [NO-1:0] model(bit fix_and, bit fix_or, logic [3:0] v);
    logic [NO-1:0] o = '0;
    if (load_en) return '0;
    for (int j = 0; j < NO; j++)
      for (int k = 0; k < NT; k++) begin
        logic t, c;
        t = fix_and ? (int'(v) == k) : lit_term(am[k], v);
        c = fix_or ? ((k / (NT / NO)) == j) : om[j][k];
        if (t && c) o[j] = 1'b1;
      end
    return o;
  endfunction

  task automatic model_erase();
    for (int k = 0; k < NT; k++) am[k] = '1;
    for (int j = 0; j < NO; j++) om[j] = '1;
  endtask

  task automatic apply(input logic [3:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    x = v;
    e.pla = model(1'b0, 1'b0, v);
    e.rom = model(1'b1, 1'b0, v);
    e.pal = model(1'b0, 1'b1, v);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic sweep(input string tag);
    for (int v = 0; v < 16; v++) apply(4'(v), tag);
  endtask

  task automatic cfg_write(input logic plane, input logic [3:0] addr, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_plane = plane; cfg_addr = addr; cfg_data = data;
    @(negedge clk);
    cfg_we = 1'b0;
    if (load_en) begin
      if (!plane) am[addr] = data[7:0];
      else if (int'(addr) < NO) om[addr] = data;
    end
  endtask

  task automatic cfg_wipe();
    @(negedge clk);
    cfg_erase = 1'b1;
    @(negedge clk);
    cfg_erase = 1'b0;
    if (load_en) model_erase();
  endtask

  task automatic set_load(input logic v);
    @(negedge clk);
    load_en = v;
  endtask

  task automatic chk(input logic [NO-1:0] got, input logic [NO-1:0] exp, input string who, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s [%s] x=%h actual=%h expected=%h", tag, who, x, got, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0) begin
        e = q.pop_front();
        chk(y_pla, e.pla, "full", e.tag);
        chk(y_rom, e.rom, "decoder", e.tag);
        chk(y_pal, e.pal, "grouped", e.tag);
      end
    end
  end

  initial begin : watchdog
    #(8 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    model_erase();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5: erased state after reset
    apply(4'h0, "R5 reset");
    apply(4'h9, "R5 reset");
    apply(4'hF, "R5 reset");

    // R7: load window forces outputs low
    set_load(1'b1);
    apply(4'h3, "R7 load window");
    apply(4'hC, "R7 load window");

    // R6: program both planes
    cfg_write(1'b0, 4'd0, 16'h0009);
    cfg_write(1'b0, 4'd1, 16'h0010);
    cfg_write(1'b0, 4'd2, 16'h0000);
    cfg_write(1'b0, 4'd3, 16'h00C0);
    cfg_write(1'b0, 4'd4, 16'h0002);
    cfg_write(1'b0, 4'd5, 16'h0054);
    cfg_write(1'b1, 4'd0, 16'h0003);
    cfg_write(1'b1, 4'd1, 16'h0004);
    cfg_write(1'b1, 4'd2, 16'h0000);
    cfg_write(1'b1, 4'd3, 16'h0038);
    cfg_write(1'b1, 4'd6, 16'hFFFF);
    apply(4'h5, "R7 load window");
    set_load(1'b0);

    // R1 R2 R3 R4 R8 R9: full input sweep on the loaded map
    sweep("R1 R2 R3 R4 R8 R9 sweep");

    // R6: writes outside the load window are ignored
    cfg_write(1'b0, 4'd2, 16'h00FF);
    cfg_write(1'b1, 4'd2, 16'hFFFF);
    sweep("R6 write outside window");

    // R5: erase returns the loadable planes to intact links
    set_load(1'b1);
    cfg_wipe();
    set_load(1'b0);
    sweep("R5 erase");

    // R3 R6: reprogram a single blank term driving output 2
    set_load(1'b1);
    cfg_write(1'b0, 4'd8, 16'h0000);
    cfg_write(1'b1, 4'd2, 16'h0100);
    cfg_write(1'b1, 4'd0, 16'h0000);
    set_load(1'b0);
    sweep("R3 R6 reprogram");

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule